// File: doc/BRIEF.md
# Intersection Signal Phase Controller

This block sequences the signal lamps of a two-approach road crossing. One approach runs north/south (NS) and the other east/west (EW). Each approach has a green, a yellow and a red lamp, and there is one pedestrian walk lamp. A one-hot phase register selects exactly one phase at a time. A phase timer advances on a one-second tick enable, and every phase length is a fixed parameter. The normal loop gives NS its green, yellow and red phases, then an all-red clearance, then EW green, yellow and red, and then returns to NS green.

A walk request button sets a sticky request flag. When that flag is set at the end of the NS red phase, the controller inserts a walk phase ahead of the clearance. During the walk phase every vehicle lamp is red. An emergency input has top priority. It forces every lamp to red on the next clock edge and holds a timed all-red interval, after which the loop restarts at NS green. When the run enable is low, or while reset is held, every vehicle lamp stays red and the loop starts again from NS green once run returns.

The lamp outputs are registered from the next-phase decode. A lamp therefore changes on the same edge as the phase register, and no single-cycle mixed lamp pattern can appear.

Top module: `xsig_phase_ctrl`

## Requirements
- R1: With run high and no emergency, the phases repeat in this order: NS green, NS yellow, NS red, all-red clearance, EW green, EW yellow, EW red, NS green. When the walk request is set at the end of NS red, a walk phase is placed between NS red and the clearance.
- R2: The phase register holds exactly one active bit in every cycle. Each approach shows exactly one of its three lamps at any time.
- R3: With a tick on every clock, the default lengths are 30 clocks for green, 5 for yellow, 3 for each approach's red phase and 2 for the clearance (the clearance parameter is meant to lie between 2 and 4). Between NS yellow and EW green all lamps are red for 5 clocks. Between EW yellow and NS green they are red for 3 clocks.
- R4: Green or yellow is never lit on both approaches at once. EW green is entered only from a cycle in which every vehicle lamp is red.
- R5: When the walk button is high at a clock edge, the walk request flag is set. The controller tests the flag when NS red completes. If the flag is set it enters the walk phase, and otherwise it goes straight to the clearance.
- R6: During the walk phase the walk output is high and every vehicle lamp is red, for 25 clocks by default (the parameter is meant to lie between 20 and 30).
- R7: The walk request is cleared only on the tick that completes the walk phase; a button press in that same cycle keeps it set. The wrap from EW red back to NS green does not clear it.
- R8: While run is high, a high emergency input at a clock edge turns every vehicle lamp red and the walk output off from that edge on, with no green in between.
- R9: The emergency hold timer stays at zero while the emergency input is high. NS green returns on the 15th tick after the input drops.
- R10: When reset is high or run is low, every vehicle lamp is red and the walk output is off after the next edge. When run returns high, NS green appears on the next edge and lasts its full length.
- R11: The phase timer counts only clocks with the tick enable high. It restarts from zero on every phase entry, and the phase advances on the tick where the count equals the phase length minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-second timing enable, one clock wide |
| run | input | 1 | Run enable; low holds all red |
| ped_btn | input | 1 | Pedestrian walk request button |
| emerg | input | 1 | Emergency preemption request |
| ns_grn | output | 1 | NS green lamp |
| ns_yel | output | 1 | NS yellow lamp |
| ns_red | output | 1 | NS red lamp |
| ew_grn | output | 1 | EW green lamp |
| ew_yel | output | 1 | EW yellow lamp |
| ew_red | output | 1 | EW red lamp |
| walk | output | 1 | Pedestrian walk lamp |

## Verification
The bound checker watches several rules on every cycle. It checks that the phase register is one-hot and that each approach lights exactly one lamp. It checks that green or yellow never shows on both approaches and that EW green is entered only out of all red. It also checks that the walk lamp shows only with all vehicle lamps red, and that emergency or a low run turns the lamps red on the next edge. Finally, it checks that the walk request falls only out of the walk phase and that a walk phase begins only with a pending request. The directed scenarios measure what a single-cycle property cannot. They measure the exact length of each phase and each all-red gap. They show that a request pressed during EW green survives the wrap and is served at the next NS red. They show the 15-tick hold that counts from the drop of a long emergency, the full-length restart after run returns, and the stretching of a phase while ticks are withheld.

// File: rtl/xsig_pkg.sv
package xsig_pkg;

    // Phase indices into the one-hot phase vector.
    // The normal loop order is fixed by the sequencer, not by these values.
    localparam int PH_IDLE = 0;
    localparam int PH_NSG  = 1;
    localparam int PH_NSY  = 2;
    localparam int PH_NSR  = 3;
    localparam int PH_PED  = 4;
    localparam int PH_CLR  = 5;
    localparam int PH_EWG  = 6;
    localparam int PH_EWY  = 7;
    localparam int PH_EWR  = 8;
    localparam int PH_EMR  = 9;
    localparam int PH_N    = 10;

    typedef logic [PH_N-1:0] phase_t;

    typedef struct packed {
        logic walk;
        logic ns_g;
        logic ns_y;
        logic ns_r;
        logic ew_g;
        logic ew_y;
        logic ew_r;
    } lamps_t;

    localparam lamps_t LAMPS_ALL_RED = '{walk: 1'b0,
                                         ns_g: 1'b0, ns_y: 1'b0, ns_r: 1'b1,
                                         ew_g: 1'b0, ew_y: 1'b0, ew_r: 1'b1};

    function automatic phase_t ph_bit(input int idx);
        phase_t p;
        p      = '0;
        p[idx] = 1'b1;
        return p;
    endfunction

    // Lamp pattern shown for a given phase. Any phase that is not green,
    // yellow or walk leaves all vehicle lamps red.
    function automatic lamps_t lamps_of(input phase_t p);
        lamps_t l;
        l = LAMPS_ALL_RED;
        if (p[PH_NSG]) begin
            l.ns_g = 1'b1;
            l.ns_r = 1'b0;
        end
        if (p[PH_NSY]) begin
            l.ns_y = 1'b1;
            l.ns_r = 1'b0;
        end
        if (p[PH_EWG]) begin
            l.ew_g = 1'b1;
            l.ew_r = 1'b0;
        end
        if (p[PH_EWY]) begin
            l.ew_y = 1'b1;
            l.ew_r = 1'b0;
        end
        if (p[PH_PED]) begin
            l.walk = 1'b1;
        end
        return l;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xsig_tick_timer.sv
// Phase timer: counts tick enables, restarts on load, and flags the
// completing tick when the count reaches the length minus one.
module xsig_tick_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          tick,
    input  logic [TW-1:0] dur,
    output logic          done
);

    logic [TW-1:0] cnt_q;

    assign done = tick && (cnt_q == (dur - TW'(1)));

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

endmodule

// File: rtl/xsig_ped_latch.sv
// Sticky walk request: set by the button, cleared only when the walk
// phase completes. A press in the clearing cycle keeps it set.
module xsig_ped_latch (
    input  logic clk,
    input  logic rst,
    input  logic press,
    input  logic clr,
    output logic req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else if (press) begin
            req <= 1'b1;
        end else if (clr) begin
            req <= 1'b0;
        end
    end

endmodule

// File: rtl/xsig_phase_seq.sv
// Next-phase logic. Priority order: run low, then emergency, then the
// normal loop.
module xsig_phase_seq
    import xsig_pkg::*;
(
    input  phase_t cur,
    input  logic   run,
    input  logic   emerg,
    input  logic   done,
    input  logic   ped_req,
    output phase_t nxt,
    output logic   load
);

    always_comb begin
        nxt  = cur;
        load = 1'b0;
        if (!run) begin
            nxt  = ph_bit(PH_IDLE);
            load = 1'b1;
        end else if (emerg) begin
            // Re-arms every cycle the input stays high.
            nxt  = ph_bit(PH_EMR);
            load = 1'b1;
        end else begin
            case (1'b1)
                cur[PH_IDLE]: nxt = ph_bit(PH_NSG);
                cur[PH_NSG]:  if (done) nxt = ph_bit(PH_NSY);
                cur[PH_NSY]:  if (done) nxt = ph_bit(PH_NSR);
                cur[PH_NSR]:  if (done) nxt = ped_req ? ph_bit(PH_PED) : ph_bit(PH_CLR);
                cur[PH_PED]:  if (done) nxt = ph_bit(PH_CLR);
                cur[PH_CLR]:  if (done) nxt = ph_bit(PH_EWG);
                cur[PH_EWG]:  if (done) nxt = ph_bit(PH_EWY);
                cur[PH_EWY]:  if (done) nxt = ph_bit(PH_EWR);
                cur[PH_EWR]:  if (done) nxt = ph_bit(PH_NSG);
                cur[PH_EMR]:  if (done) nxt = ph_bit(PH_NSG);
                default:      nxt = ph_bit(PH_IDLE);
            endcase
            load = (nxt != cur);
        end
    end

endmodule

// File: rtl/xsig_phase_ctrl.sv
// Intersection phase controller top level.
module xsig_phase_ctrl
    import xsig_pkg::*;
#(
    parameter int unsigned GREEN_S  = 30,
    parameter int unsigned YELLOW_S = 5,
    parameter int unsigned RED_S    = 3,
    parameter int unsigned CLEAR_S  = 2,   // intended range 2..4
    parameter int unsigned WALK_S   = 25,  // intended range 20..30
    parameter int unsigned HOLD_S   = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_1s,
    input  logic run,
    input  logic ped_btn,
    input  logic emerg,
    output logic ns_grn,
    output logic ns_yel,
    output logic ns_red,
    output logic ew_grn,
    output logic ew_yel,
    output logic ew_red,
    output logic walk
);

    localparam int unsigned MAX_D = max_of(max_of(max_of(GREEN_S, YELLOW_S), max_of(RED_S, CLEAR_S)),
                                           max_of(WALK_S, HOLD_S));
    localparam int TW = $clog2(MAX_D + 1);

    // Length of each phase, indexed by phase number.
    localparam logic [TW-1:0] DUR_TAB [PH_N] = '{
        TW'(1),        // idle
        TW'(GREEN_S),  // NS green
        TW'(YELLOW_S), // NS yellow
        TW'(RED_S),    // NS red
        TW'(WALK_S),   // walk
        TW'(CLEAR_S),  // clearance
        TW'(GREEN_S),  // EW green
        TW'(YELLOW_S), // EW yellow
        TW'(RED_S),    // EW red
        TW'(HOLD_S)    // emergency hold
    };

    phase_t        phase_q;
    phase_t        phase_d;
    logic          load;
    logic          done;
    logic          ped_req;
    logic [TW-1:0] dur;
    lamps_t        lamps_q;

    always_comb begin
        dur = '0;
        for (int i = 0; i < PH_N; i++) begin
            if (phase_q[i]) begin
                dur = dur | DUR_TAB[i];
            end
        end
    end

    xsig_tick_timer #(.TW(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .tick (tick_1s),
        .dur  (dur),
        .done (done)
    );

    xsig_ped_latch u_ped (
        .clk   (clk),
        .rst   (rst),
        .press (ped_btn),
        .clr   (phase_q[PH_PED] && done),
        .req   (ped_req)
    );

    xsig_phase_seq u_seq (
        .cur     (phase_q),
        .run     (run),
        .emerg   (emerg),
        .done    (done),
        .ped_req (ped_req),
        .nxt     (phase_d),
        .load    (load)
    );

    // Phase and lamp registers update on the same edge; lamps decode the
    // next phase so no mixed pattern is ever shown.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ph_bit(PH_IDLE);
            lamps_q <= LAMPS_ALL_RED;
        end else begin
            phase_q <= phase_d;
            lamps_q <= lamps_of(phase_d);
        end
    end

    assign ns_grn = lamps_q.ns_g;
    assign ns_yel = lamps_q.ns_y;
    assign ns_red = lamps_q.ns_r;
    assign ew_grn = lamps_q.ew_g;
    assign ew_yel = lamps_q.ew_y;
    assign ew_red = lamps_q.ew_r;
    assign walk   = lamps_q.walk;

endmodule

// File: rtl/xsig_phase_chk.sv
module xsig_phase_chk
    import xsig_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   run,
    input logic   emerg,
    input phase_t phase_q,
    input logic   ped_req,
    input lamps_t lamps
);

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_q) == 1); // R2

    AST_ONE_LAMP_PER_DIR: assert property (@(posedge clk) disable iff (rst)
        ($countones({lamps.ns_g, lamps.ns_y, lamps.ns_r}) == 1) &&
        ($countones({lamps.ew_g, lamps.ew_y, lamps.ew_r}) == 1)); // R2

    AST_NO_DUAL_GO: assert property (@(posedge clk) disable iff (rst)
        !((lamps.ns_g || lamps.ns_y) && (lamps.ew_g || lamps.ew_y))); // R4

    AST_EW_GREEN_FROM_RED: assert property (@(posedge clk) disable iff (rst)
        $rose(lamps.ew_g) |-> $past(lamps.ns_r && lamps.ew_r)); // R4

    AST_WALK_ALL_RED: assert property (@(posedge clk) disable iff (rst)
        lamps.walk |-> (lamps.ns_r && lamps.ew_r)); // R6

    AST_WALK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(lamps.walk) |-> $past(ped_req)); // R5

    AST_REQ_CLEARS_IN_WALK: assert property (@(posedge clk) disable iff (rst)
        $fell(ped_req) |-> $past(phase_q[PH_PED])); // R7

    AST_PREEMPT_RED: assert property (@(posedge clk) disable iff (rst)
        (run && emerg) |=> (lamps.ns_r && lamps.ew_r && !lamps.walk)); // R8

    AST_STOPPED_RED: assert property (@(posedge clk) disable iff (rst)
        !run |=> (lamps.ns_r && lamps.ew_r && !lamps.walk)); // R10

endmodule

bind xsig_phase_ctrl xsig_phase_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .emerg   (emerg),
    .phase_q (phase_q),
    .ped_req (ped_req),
    .lamps   (lamps_q)
);

// File: tb/sim_xsig_phase_ctrl.sv
module sim_xsig_phase_ctrl;

    localparam int CLK_PERIOD = 10;

    // Pattern = {walk, ew_red, ew_yel, ew_grn, ns_red, ns_yel, ns_grn}
    localparam logic [6:0] P_NSG  = 7'b0100001;
    localparam logic [6:0] P_NSY  = 7'b0100010;
    localparam logic [6:0] P_AR   = 7'b0100100;
    localparam logic [6:0] P_EWG  = 7'b0001100;
    localparam logic [6:0] P_EWY  = 7'b0010100;
    localparam logic [6:0] P_WALK = 7'b1100100;

    logic clk = 1'b0;
    logic rst, tick_1s, run, ped_btn, emerg;
    logic ns_grn, ns_yel, ns_red, ew_grn, ew_yel, ew_red, walk;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xsig_phase_ctrl u0 (
        .clk(clk), .rst(rst), .tick_1s(tick_1s), .run(run),
        .ped_btn(ped_btn), .emerg(emerg),
        .ns_grn(ns_grn), .ns_yel(ns_yel), .ns_red(ns_red),
        .ew_grn(ew_grn), .ew_yel(ew_yel), .ew_red(ew_red), .walk(walk)
    );

    function automatic logic [6:0] pat();
        return {walk, ew_red, ew_yel, ew_grn, ns_red, ns_yel, ns_grn};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_pat(input logic [6:0] p, input string req);
        chk(pat() == p, req, int'(pat()), int'(p));
    endtask

    // Counts consecutive negedge samples showing pattern p, starting with
    // the current sample; returns with the first differing sample current.
    task automatic expect_len(input logic [6:0] p, input int exp, input string req);
        int n;
        n = 0;
        while (pat() == p && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp, req, n, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; run = 1'b1; tick_1s = 1'b1; ped_btn = 1'b0; emerg = 1'b0;
        repeat (3) @(negedge clk);
        chk_pat(P_AR, "R10 reset all red");
        rst = 1'b0;
        @(negedge clk);
        chk_pat(P_NSG, "R10 NS green after reset release");
    endtask

    task automatic t_sequence();
        expect_len(P_NSG, 30, "R3 NS green length");
        expect_len(P_NSY, 5,  "R3 NS yellow length");
        expect_len(P_AR,  5,  "R1 R3 NS red plus clearance");
        expect_len(P_EWG, 30, "R3 EW green length");
        expect_len(P_EWY, 5,  "R1 EW yellow length");
        expect_len(P_AR,  3,  "R1 EW red length");
        chk_pat(P_NSG, "R1 wrap to NS green");
    endtask

    task automatic t_walk();
        ped_btn = 1'b1;
        @(negedge clk);
        ped_btn = 1'b0;
        expect_len(P_NSG,  29, "R5 NS green unchanged by press");
        expect_len(P_NSY,  5,  "R5 NS yellow");
        expect_len(P_AR,   3,  "R5 NS red before walk");
        expect_len(P_WALK, 25, "R6 walk length");
        expect_len(P_AR,   2,  "R1 clearance after walk");
        expect_len(P_EWG,  30, "R1 EW green after walk");
        expect_len(P_EWY,  5,  "R1 EW yellow");
        expect_len(P_AR,   3,  "R1 EW red");
        expect_len(P_NSG,  30, "R7 next NS green");
        expect_len(P_NSY,  5,  "R7 next NS yellow");
        expect_len(P_AR,   5,  "R7 request served once, no second walk");
    endtask

    task automatic t_wrap();
        ped_btn = 1'b1;
        @(negedge clk);
        ped_btn = 1'b0;
        expect_len(P_EWG,  29, "R7 EW green with pending request");
        expect_len(P_EWY,  5,  "R7 EW yellow");
        expect_len(P_AR,   3,  "R7 EW red");
        expect_len(P_NSG,  30, "R7 NS green after wrap");
        expect_len(P_NSY,  5,  "R7 NS yellow after wrap");
        expect_len(P_AR,   3,  "R7 NS red before walk");
        expect_len(P_WALK, 25, "R7 request kept across wrap");
        expect_len(P_AR,   2,  "R4 clearance before EW green");
        chk_pat(P_EWG, "R4 EW green after clearance");
    endtask

    task automatic t_emerg();
        int okc;
        repeat (3) @(negedge clk);
        emerg = 1'b1;
        @(negedge clk);
        chk_pat(P_AR, "R8 preempt all red next edge");
        okc = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pat() == P_AR) okc++;
        end
        chk(okc == 40, "R9 hold re-arms while input high", okc, 40);
        emerg = 1'b0;
        @(negedge clk);
        expect_len(P_AR, 14, "R9 hold after drop");
        chk_pat(P_NSG, "R9 NS green on 15th tick after drop");
    endtask

    task automatic t_run();
        int okc;
        repeat (2) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk_pat(P_AR, "R10 run low all red");
        okc = 0;
        for (int i = 0; i < 10; i++) begin
            ped_btn = (i == 3);
            @(negedge clk);
            if (pat() == P_AR) okc++;
        end
        ped_btn = 1'b0;
        chk(okc == 10, "R10 all red held while stopped", okc, 10);
        run = 1'b1;
        @(negedge clk);
        expect_len(P_NSG, 30, "R10 full NS green on restart");
        expect_len(P_NSY, 5,  "R10 NS yellow on restart");
        expect_len(P_AR,  3,  "R5 press while stopped served");
        chk_pat(P_WALK, "R5 walk after NS red");
        expect_len(P_WALK, 25, "R6 walk length again");
        expect_len(P_AR,   2,  "R1 clearance");
    endtask

    task automatic t_tick();
        int okc;
        chk_pat(P_EWG, "R11 at EW green entry");
        for (int i = 0; i < 10; i++) @(negedge clk);
        tick_1s = 1'b0;
        okc = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pat() == P_EWG) okc++;
        end
        chk(okc == 50, "R11 no advance without tick", okc, 50);
        tick_1s = 1'b1;
        expect_len(P_EWG, 20, "R11 remaining ticks after stall");
        chk_pat(P_EWY, "R11 advance to EW yellow");
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_walk();
        t_wrap();
        t_emerg();
        t_run();
        t_tick();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule